// File: doc/BRIEF.md
# Gapped Line Copy Engine

This block copies a run of payload bytes from a source buffer to a destination buffer. Each buffer is laid out as lines: a fixed number of payload bytes, then a gap of bytes that are skipped. Source and destination carry their own line width and gap, so the data is repacked from one stride to the other as it moves. The byte count given with the command counts payload only and never the gap bytes.

Software places a source base, a destination base, a payload byte total and one 32-bit line descriptor per side on the inputs and pulses `start`. The engine checks the parameters. If they are valid, it issues 8-byte reads on a read port and places the returned beats in a small FIFO. It drains the FIFO into 8-byte writes on a write port. Once every write has been acknowledged by the memory, it raises a one-cycle completion interrupt. Bad parameters end the command at once with an error flag, and no memory traffic is issued.

Top module: `tcopy_engine`

## Requirements
- R1: While reset is held and directly after it, `busy`, `err`, `done_irq`, `rd_req` and `wr_req` are all low.
- R2: A `start` taken while idle is rejected if any of the following holds: either base address is not a multiple of 8, the byte total is not a multiple of 8, the byte total is zero, either line size is zero, or any line size or gap is not a multiple of 8. On rejection, `err` and `done_irq` are high in the next cycle, `busy` stays low, and no read or write request is raised.
- R3: A valid `start` taken while idle raises `busy` and clears `err` in the next cycle.
- R4: In each line descriptor, bits 15:0 hold the line size in bytes and bits 31:16 hold the gap in bytes. The first accepted read is at the source base. Each later read is 8 bytes above the previous one. After the read that finishes a line (line size bytes into it), the next read address is additionally advanced by the source gap.
- R5: Accepted write addresses follow the rule of R4, using the destination base and the destination descriptor. This stepping is independent of the read side.
- R6: A command moves exactly byte total / 8 read beats and the same number of write beats. Gap bytes are neither read nor written. Requests are raised only while `busy` is high.
- R7: The data of the n-th accepted write equals the data returned for the n-th accepted read.
- R8: The number of accepted reads minus the number of accepted writes never exceeds the FIFO depth, which is 4 by default.
- R9: `busy` stays high until the acknowledge of the last write. In the cycle after that acknowledge, `busy` is low and `done_irq` is high for exactly one cycle.
- R10: A `start` that arrives while `busy` is high has no effect, whatever its parameters: `err` stays low and the running copy continues unchanged.
- R11: A read request that is not accepted stays raised with the same address in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Command strobe, taken only while idle |
| src_base | input | AW | Source start address |
| dst_base | input | AW | Destination start address |
| byte_total | input | CNT_W | Payload bytes to move, gaps excluded |
| src_desc | input | 32 | Source line descriptor: [15:0] line bytes, [31:16] gap bytes |
| dst_desc | input | 32 | Destination line descriptor, same layout |
| busy | output | 1 | Copy in progress |
| err | output | 1 | Last command was rejected |
| done_irq | output | 1 | One-cycle completion pulse |
| rd_req | output | 1 | Read request |
| rd_addr | output | AW | Read address |
| rd_ready | input | 1 | Read request accepted this cycle |
| rd_valid | input | 1 | Read data returned this cycle, in request order |
| rd_data | input | 64 | Read data beat |
| wr_req | output | 1 | Write request |
| wr_addr | output | AW | Write address |
| wr_data | output | 64 | Write data beat |
| wr_ready | input | 1 | Write request accepted this cycle |
| wr_ack | input | 1 | One accepted write has completed |

## Verification
A wrong line position counter or a wrong gap add shows up as a bad address on the first beat after a line boundary. This happens within one line's worth of beats of the fault. A fault in the FIFO pointers or the in-flight count shows up as wrong or reordered write data, or as reads that run more than four beats ahead of writes, at the next handshake. A fault in a beat or acknowledge counter shifts the fall of `busy` and the completion pulse by at least a cycle. A fault in the launch decode shows up as traffic or a missing error flag in the cycle right after `start`. The reference model is compared on every clock under random stalls on both ports, so each of these faults appears at the first cycle where it is visible at the ports.

// File: rtl/tcopy_pkg.sv
package tcopy_pkg;
  localparam int BEAT_BYTES = 8;
  localparam int BEAT_SHIFT = 3;
  localparam int BEAT_BITS  = BEAT_BYTES * 8;

  // line descriptor: upper half is the skip distance, lower half the payload width
  typedef struct packed {
    logic [15:0] gap;
    logic [15:0] line;
  } line_desc_t;

  function automatic logic desc_bad(input line_desc_t d);
    return (d.line == 16'd0) ||
           (d.line[BEAT_SHIFT-1:0] != '0) ||
           (d.gap[BEAT_SHIFT-1:0] != '0);
  endfunction

  // true when the beat at position pos closes a line of the given width
  function automatic logic closes_line(input logic [15:0] pos, input logic [15:0] line);
    return ({1'b0, pos} + 17'(BEAT_BYTES)) >= {1'b0, line};
  endfunction
endpackage

// File: rtl/tcopy_walker.sv
module tcopy_walker
  import tcopy_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] base,
  input  line_desc_t    desc,
  output logic [AW-1:0] addr
);
  line_desc_t  d_q;
  logic [15:0] pos_q;
  logic        line_done;

  assign line_done = closes_line(pos_q, d_q.line);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr  <= '0;
      pos_q <= '0;
      d_q   <= '0;
    end else if (load) begin
      addr  <= base;
      pos_q <= '0;
      d_q   <= desc;
    end else if (step) begin
      if (line_done) begin
        addr  <= addr + AW'(BEAT_BYTES) + AW'(d_q.gap);
        pos_q <= '0;
      end else begin
        addr  <= addr + AW'(BEAT_BYTES);
        pos_q <= pos_q + 16'(BEAT_BYTES);
      end
    end
  end
endmodule

// File: rtl/tcopy_fifo.sv
module tcopy_fifo #(
  parameter int DW    = 64,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [DW-1:0]              din,
  input  logic                       pop,
  output logic [DW-1:0]              dout,
  output logic [$clog2(DEPTH+1)-1:0] fill
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign dout = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      case ({push, pop})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/tcopy_engine.sv
module tcopy_engine
  import tcopy_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CNT_W      = 32,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [AW-1:0]        src_base,
  input  logic [AW-1:0]        dst_base,
  input  logic [CNT_W-1:0]     byte_total,
  input  logic [31:0]          src_desc,
  input  logic [31:0]          dst_desc,
  output logic                 busy,
  output logic                 err,
  output logic                 done_irq,
  output logic                 rd_req,
  output logic [AW-1:0]        rd_addr,
  input  logic                 rd_ready,
  input  logic                 rd_valid,
  input  logic [BEAT_BITS-1:0] rd_data,
  output logic                 wr_req,
  output logic [AW-1:0]        wr_addr,
  output logic [BEAT_BITS-1:0] wr_data,
  input  logic                 wr_ready,
  input  logic                 wr_ack
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic             busy_q, err_q, done_q;
  logic [CNT_W-1:0] rd_left, ack_left;
  logic [CW-1:0]    inflight, fifo_fill;
  logic             params_good;

  // named internal events
  logic start_take, launch, reject, rd_fire, wr_fire, last_ack;

  always_comb begin
    params_good = (src_base[BEAT_SHIFT-1:0] == '0) &&
                  (dst_base[BEAT_SHIFT-1:0] == '0) &&
                  (byte_total[BEAT_SHIFT-1:0] == '0) &&
                  (byte_total != '0) &&
                  !desc_bad(line_desc_t'(src_desc)) &&
                  !desc_bad(line_desc_t'(dst_desc));
  end

  assign start_take = start && !busy_q;
  assign launch     = start_take && params_good;
  assign reject     = start_take && !params_good;
  assign rd_req     = busy_q && (rd_left != '0) && (inflight < CW'(FIFO_DEPTH));
  assign wr_req     = busy_q && (fifo_fill != '0);
  assign rd_fire    = rd_req && rd_ready;
  assign wr_fire    = wr_req && wr_ready;
  assign last_ack   = busy_q && wr_ack && (ack_left == CNT_W'(1));

  assign busy     = busy_q;
  assign err      = err_q;
  assign done_irq = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
      rd_left  <= '0;
      ack_left <= '0;
      inflight <= '0;
    end else begin
      done_q <= last_ack || reject;
      if (launch) begin
        busy_q   <= 1'b1;
        err_q    <= 1'b0;
        rd_left  <= byte_total >> BEAT_SHIFT;
        ack_left <= byte_total >> BEAT_SHIFT;
        inflight <= '0;
      end else begin
        if (reject) err_q <= 1'b1;
        if (last_ack) busy_q <= 1'b0;
        if (rd_fire) rd_left <= rd_left - CNT_W'(1);
        if (busy_q && wr_ack) ack_left <= ack_left - CNT_W'(1);
        case ({rd_fire, wr_fire})
          2'b10:   inflight <= inflight + CW'(1);
          2'b01:   inflight <= inflight - CW'(1);
          default: inflight <= inflight;
        endcase
      end
    end
  end

  tcopy_walker #(.AW(AW)) u_src_walk (
    .clk  (clk),
    .rst_n(rst_n),
    .load (launch),
    .step (rd_fire),
    .base (src_base),
    .desc (line_desc_t'(src_desc)),
    .addr (rd_addr)
  );

  tcopy_walker #(.AW(AW)) u_dst_walk (
    .clk  (clk),
    .rst_n(rst_n),
    .load (launch),
    .step (wr_fire),
    .base (dst_base),
    .desc (line_desc_t'(dst_desc)),
    .addr (wr_addr)
  );

  tcopy_fifo #(.DW(BEAT_BITS), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .push (rd_valid && busy_q),
    .din  (rd_data),
    .pop  (wr_fire),
    .dout (wr_data),
    .fill (fifo_fill)
  );
endmodule

// File: rtl/tcopy_engine_chk.sv
module tcopy_engine_chk #(
  parameter int AW    = 32,
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          err,
  input logic          done_irq,
  input logic          rd_req,
  input logic          rd_ready,
  input logic [AW-1:0] rd_addr,
  input logic          wr_req,
  input logic [CW-1:0] fill
);
  a_r2_err_idle: assert property (@(posedge clk) disable iff (!rst_n) err |-> !busy);
  a_r6_read_busy: assert property (@(posedge clk) disable iff (!rst_n) rd_req |-> busy);
  a_r2_write_busy: assert property (@(posedge clk) disable iff (!rst_n) wr_req |-> busy);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n) done_irq |=> !done_irq);
  a_r9_busy_fall: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done_irq);
  a_r11_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ready) |=> (rd_req && $stable(rd_addr)));
  a_r8_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n) fill <= CW'(DEPTH));
  a_r4_read_align: assert property (@(posedge clk) disable iff (!rst_n) rd_req |-> (rd_addr[2:0] == 3'd0));
endmodule

bind tcopy_engine tcopy_engine_chk #(.AW(AW), .DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .err     (err),
  .done_irq(done_irq),
  .rd_req  (rd_req),
  .rd_ready(rd_ready),
  .rd_addr (rd_addr),
  .wr_req  (wr_req),
  .fill    (fifo_fill)
);

// File: tb/tcopy_engine_test.sv
module tcopy_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] src_base = '0, dst_base = '0, byte_total = '0, src_desc = '0, dst_desc = '0;
  logic        busy, err, done_irq, rd_req, wr_req;
  logic [31:0] rd_addr, wr_addr;
  logic [63:0] wr_data;
  logic        rd_ready = 1'b0, rd_valid = 1'b0, wr_ready = 1'b0, wr_ack = 1'b0;
  logic [63:0] rd_data = '0;

  always #4 clk = ~clk;

  tcopy_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_base(src_base), .dst_base(dst_base),
    .byte_total(byte_total), .src_desc(src_desc), .dst_desc(dst_desc),
    .busy(busy), .err(err), .done_irq(done_irq),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready), .wr_ack(wr_ack)
  );

  int checks = 0, errors = 0;
  bit summary_done = 1'b0;

  // reference model state
  bit m_busy = 0, m_err = 0, m_done = 0;
  int acks_pending = 0, acks_left = 0, n_rd = 0, n_wr = 0;
  logic [31:0] exp_rd[$], exp_wr[$], resp_q[$];
  logic [63:0] exp_dat[$];
  bit req_pending = 0, poke_pending = 0, hold_rd = 0;
  logic [31:0] hold_addr = '0;
  int pct = 70;
  logic [31:0] j_src, j_dst, j_tot, j_sd, j_dd;

  function automatic logic [63:0] pat(input logic [31:0] a);
    return {a ^ 32'h5A5A_0000, ~a};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit roll();
    return $urandom_range(0, 99) < pct;
  endfunction

  task automatic tick();
    bit nb, nd, ne, good;
    logic [31:0] a;
    int pos;
    @(negedge clk);
    chk(busy === m_busy, "R3/R9 busy", busy, m_busy);
    chk(err === m_err, "R2 err", err, m_err);
    chk(done_irq === m_done, "R9 done_irq", done_irq, m_done);
    if (!m_busy) begin
      chk(rd_req === 1'b0, "R6 read while idle", rd_req, 0);
      chk(wr_req === 1'b0, "R2 write while idle", wr_req, 0);
    end
    nb = m_busy; nd = 0; ne = m_err;
    // read data return, in order
    rd_valid = 1'b0; rd_data = '0;
    if (resp_q.size() > 0 && roll()) begin
      rd_valid = 1'b1;
      rd_data = pat(resp_q.pop_front());
    end
    if (hold_rd) chk(rd_req === 1'b1 && rd_addr === hold_addr, "R11 read hold", {rd_req, rd_addr}, {1'b1, hold_addr});
    rd_ready = roll();
    hold_rd = rd_req && !rd_ready;
    hold_addr = rd_addr;
    if (rd_req && rd_ready) begin
      if (exp_rd.size() == 0) chk(0, "R6 extra read", rd_addr, 0);
      else begin
        a = exp_rd.pop_front();
        chk(rd_addr === a, "R4 read addr", rd_addr, a);
      end
      resp_q.push_back(rd_addr);
      n_rd++;
    end
    // write acknowledge
    wr_ack = 1'b0;
    if (acks_pending > 0 && roll()) begin
      wr_ack = 1'b1;
      acks_pending--;
      acks_left--;
      if (acks_left == 0) begin nb = 0; nd = 1; end
    end
    wr_ready = roll();
    if (wr_req && wr_ready) begin
      if (exp_wr.size() == 0) chk(0, "R6 extra write", wr_addr, 0);
      else begin
        a = exp_wr.pop_front();
        chk(wr_addr === a, "R5 write addr", wr_addr, a);
        chk(wr_data === exp_dat[0], "R7 write data", wr_data, exp_dat[0]);
        void'(exp_dat.pop_front());
      end
      acks_pending++;
      n_wr++;
    end
    chk((n_rd - n_wr) <= 4, "R8 read lead", n_rd - n_wr, 4);
    // command issue
    start = 1'b0;
    if (req_pending && !m_busy) begin
      req_pending = 0;
      start = 1'b1;
      src_base = j_src; dst_base = j_dst; byte_total = j_tot; src_desc = j_sd; dst_desc = j_dd;
      good = (j_src % 8 == 0) && (j_dst % 8 == 0) && (j_tot % 8 == 0) && (j_tot != 0) &&
             (j_sd[15:0] != 0) && (j_dd[15:0] != 0) &&
             (j_sd % 8 == 0) && (j_dd % 8 == 0) && (j_sd[31:16] % 8 == 0) && (j_dd[31:16] % 8 == 0);
      n_rd = 0; n_wr = 0;
      if (good) begin
        nb = 1; ne = 0;
        acks_left = j_tot / 8;
        a = j_src; pos = 0;
        for (int i = 0; i < j_tot / 8; i++) begin
          exp_rd.push_back(a);
          exp_dat.push_back(pat(a));
          pos += 8; a += 8;
          if (pos >= j_sd[15:0]) begin pos = 0; a += j_sd[31:16]; end
        end
        a = j_dst; pos = 0;
        for (int i = 0; i < j_tot / 8; i++) begin
          exp_wr.push_back(a);
          pos += 8; a += 8;
          if (pos >= j_dd[15:0]) begin pos = 0; a += j_dd[31:16]; end
        end
      end else begin
        ne = 1; nd = 1;
      end
    end else if (poke_pending && m_busy) begin
      // R10: a malformed start during a copy must be ignored
      poke_pending = 0;
      start = 1'b1;
      src_base = 32'h3; src_desc = 32'h0;
    end
    m_busy = nb; m_done = nd; m_err = ne;
  endtask

  task automatic job(input logic [31:0] s, input logic [31:0] d, input logic [31:0] t,
                     input logic [31:0] sd, input logic [31:0] dd, input int p, input bit poke);
    j_src = s; j_dst = d; j_tot = t; j_sd = sd; j_dd = dd; pct = p;
    req_pending = 1;
    tick();
    if (poke) begin repeat (3) tick(); poke_pending = 1; end
    while (req_pending || m_busy || m_done || poke_pending) tick();
    chk(exp_rd.size() == 0 && exp_wr.size() == 0, "R6 beat count", exp_rd.size() + exp_wr.size(), 0);
    chk(acks_pending == 0, "R9 acks drained", acks_pending, 0);
    repeat (2) tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, err, done_irq, rd_req, wr_req} === 5'b0, "R1 reset", {busy, err, done_irq, rd_req, wr_req}, 0);
    rst_n = 1'b1;
    tick();
    chk({busy, err, done_irq, rd_req, wr_req} === 5'b0, "R1 after reset", {busy, err, done_irq, rd_req, wr_req}, 0);
    // R4 R5 differing strides
    job(32'h1000, 32'h8000, 96, {16'd16, 16'd32}, {16'd8, 16'd24}, 70, 0);
    // narrow source lines, wide destination lines, heavy stalls
    job(32'h2000, 32'h9000, 128, {16'd0, 16'd8}, {16'd32, 16'd64}, 35, 0);
    // line wider than the payload, full speed
    job(32'h3000, 32'hA000, 40, {16'd8, 16'd256}, {16'd8, 16'd16}, 100, 0);
    // large gap jump
    job(32'h4000, 32'hB000, 48, {16'hFFF8, 16'd16}, {16'd0, 16'd8}, 80, 0);
    // R10 start while busy
    job(32'h5000, 32'hC000, 160, {16'd24, 16'd40}, {16'd16, 16'd32}, 60, 1);
    // R2 rejections
    job(32'h1004, 32'h8000, 64, {16'd0, 16'd8}, {16'd0, 16'd8}, 70, 0);
    job(32'h1000, 32'h8002, 64, {16'd0, 16'd8}, {16'd0, 16'd8}, 70, 0);
    job(32'h1000, 32'h8000, 0, {16'd0, 16'd8}, {16'd0, 16'd8}, 70, 0);
    job(32'h1000, 32'h8000, 60, {16'd0, 16'd8}, {16'd0, 16'd8}, 70, 0);
    job(32'h1000, 32'h8000, 64, {16'd0, 16'd8}, {16'd0, 16'd0}, 70, 0);
    job(32'h1000, 32'h8000, 64, {16'd4, 16'd8}, {16'd0, 16'd8}, 70, 0);
    job(32'h1000, 32'h8000, 64, {16'd0, 16'd12}, {16'd0, 16'd8}, 70, 0);
    // R3 a valid command clears the error flag
    job(32'h6000, 32'hD000, 32, {16'd8, 16'd16}, {16'd0, 16'd8}, 90, 0);
    if (!summary_done) begin
      summary_done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!summary_done) begin
      summary_done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule